// File: doc/BRIEF.md
# Register-Machine Arithmetic Unit with Compare Flags

This block is the combinational datapath core of a small register machine. It receives a 4-bit operation code and two data words, called B and C. It returns a result word, the next value of the machine's flags register, and a write enable for that register. The operations are pass-through, add, subtract, multiply, unsigned divide, logical shifts in both directions, nand and xor.

Subtract is the only operation that writes the flags, so a compare is a subtract whose result goes to a scratch register. The surrounding machine keeps the flags in an ordinary register. It feeds that register's current value in on `flags_in` and writes `flags_out` back when `flags_we` is high. Register storage, memory operands, fetch and branching belong to the surrounding machine and are not part of this block.

Top module: `rm_alu`

## Requirements
- R1: Operation code 0x1 (move) outputs operand C unchanged on `result`.
- R2: Operation code 0x2 outputs B+C and code 0x3 outputs B-C. Both wrap modulo 2^32.
- R3: Operation code 0x4 outputs the low 32 bits of the product B*C.
- R4: Operation code 0x5 outputs the unsigned quotient B/C. When C is zero the result is all ones.
- R5: Operation code 0x6 shifts B right and code 0x7 shifts B left. Both shifts are logical, fill with zeros, and use only bits [4:0] of C as the shift amount.
- R6: Operation code 0x8 outputs ~(B & C) and code 0x9 outputs B ^ C.
- R7: `flags_we` is high only for operation code 0x3. For every other code, `flags_out` equals `flags_in`.
- R8: On a subtract, flag bit 0 (sign) equals bit 31 of the difference.
- R9: On a subtract, flag bit 1 (zero) is set exactly when the difference is zero, that is, when B equals C.
- R10: On a subtract, flag bits 31..2 are written as zero, whatever `flags_in` holds.
- R11: Operation codes 0x0 and 0xA to 0xF output a zero result and leave `flags_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code |
| opnd_b | input | 32 | First source operand (B) |
| opnd_c | input | 32 | Second source operand (C); low 5 bits are the shift amount |
| flags_in | input | 32 | Current value of the flags register |
| result | output | 32 | Operation result |
| flags_out | output | 32 | Next value of the flags register |
| flags_we | output | 1 | Flags register write enable |

## Verification
The block has no registers, so every output is due in the same cycle the inputs change, with zero cycles of latency. The bench drives each new operand set on the falling clock edge. It reads `result`, `flags_out` and `flags_we` 2 ns later, before the next rising edge, after the combinational paths have settled. Because the bench never samples at an edge, no check depends on the order in which processes run. It also means no check looks at a value from an earlier stimulus.

// File: rtl/rm_alu_pkg.sv
package rm_alu_pkg;
   typedef enum logic [3:0] {
      OPC_MOVE = 4'h1,
      OPC_ADD  = 4'h2,
      OPC_SUB  = 4'h3,
      OPC_MUL  = 4'h4,
      OPC_DIV  = 4'h5,
      OPC_SHR  = 4'h6,
      OPC_SHL  = 4'h7,
      OPC_NAND = 4'h8,
      OPC_XOR  = 4'h9
   } opc_e;

   localparam int unsigned FLG_SIGN = 0;
   localparam int unsigned FLG_ZERO = 1;
endpackage

// File: rtl/rm_alu_shift.sv
module rm_alu_shift #(
   parameter int unsigned WIDTH = 32,
   localparam int unsigned AMT_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] din,
   input  logic [AMT_W-1:0] amount,
   output logic [WIDTH-1:0] right_out,
   output logic [WIDTH-1:0] left_out
);
   if ((1 << AMT_W) != WIDTH) begin : g_bad_width
      $error("rm_alu_shift: WIDTH must be a power of two");
   end

   always_comb begin
      right_out = din >> amount;
      left_out  = din << amount;
   end

   // R5: a zero shift amount returns the operand untouched in both directions
   always_comb begin
      if (amount == '0) begin
         p_zero_shift_r5: assert (right_out == din && left_out == din)
            else $error("zero-amount shift altered data");
      end
   end
endmodule

// File: rtl/rm_alu_div.sv
module rm_alu_div #(
   parameter int unsigned WIDTH    = 32,
   parameter bit          USE_ARRAY = 1'b1
) (
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic [WIDTH-1:0] quotient
);
   logic [WIDTH-1:0] q_raw;

   if (USE_ARRAY) begin : g_restoring
      always_comb begin
         logic [WIDTH:0] rem;
         rem   = '0;
         q_raw = '0;
         for (int i = WIDTH - 1; i >= 0; i--) begin
            rem = {rem[WIDTH-1:0], dividend[i]};
            if (rem >= {1'b0, divisor}) begin
               rem      = rem - {1'b0, divisor};
               q_raw[i] = 1'b1;
            end
         end
      end
   end else begin : g_operator
      always_comb q_raw = (divisor == '0) ? '0 : dividend / divisor;
   end

   assign quotient = (divisor == '0) ? '1 : q_raw;

   // R4: a nonzero quotient times the divisor never exceeds the dividend
   always_comb begin
      if (divisor != '0) begin
         p_quot_bound_r4: assert ({{WIDTH{1'b0}}, quotient} * {{WIDTH{1'b0}}, divisor}
                                  <= {{WIDTH{1'b0}}, dividend})
            else $error("quotient too large");
      end
   end
endmodule

// File: rtl/rm_alu_flags.sv
module rm_alu_flags #(
   parameter int unsigned WIDTH    = 32,
   parameter int unsigned SIGN_POS = 0,
   parameter int unsigned ZERO_POS = 1
) (
   input  logic             write_en,
   input  logic [WIDTH-1:0] diff,
   input  logic [WIDTH-1:0] flags_cur,
   output logic [WIDTH-1:0] flags_nxt
);
   if (SIGN_POS >= WIDTH || ZERO_POS >= WIDTH || SIGN_POS == ZERO_POS) begin : g_bad_pos
      $error("rm_alu_flags: flag positions must be distinct and inside the word");
   end

   logic [WIDTH-1:0] fresh;

   always_comb begin
      fresh           = '0;
      fresh[SIGN_POS] = diff[WIDTH-1];
      fresh[ZERO_POS] = (diff == '0);
      flags_nxt       = write_en ? fresh : flags_cur;
   end
endmodule

// File: rtl/rm_alu.sv
module rm_alu
   import rm_alu_pkg::*;
#(
   parameter int unsigned WIDTH     = 32,
   parameter bit          DIV_ARRAY = 1'b1,
   localparam int unsigned AMT_W    = $clog2(WIDTH)
) (
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [WIDTH-1:0] opnd_c,
   input  logic [WIDTH-1:0] flags_in,
   output logic [WIDTH-1:0] result,
   output logic [WIDTH-1:0] flags_out,
   output logic             flags_we
);
   if (WIDTH < 8) begin : g_bad_width
      $error("rm_alu: WIDTH must be at least 8");
   end

   logic [WIDTH-1:0] sum, diff, prod, quot, shr_v, shl_v;

   assign sum  = opnd_b + opnd_c;
   assign diff = opnd_b - opnd_c;
   assign prod = opnd_b * opnd_c;

   rm_alu_div #(.WIDTH(WIDTH), .USE_ARRAY(DIV_ARRAY)) u_div (
      .dividend(opnd_b), .divisor(opnd_c), .quotient(quot)
   );

   rm_alu_shift #(.WIDTH(WIDTH)) u_shift (
      .din(opnd_b), .amount(opnd_c[AMT_W-1:0]),
      .right_out(shr_v), .left_out(shl_v)
   );

   always_comb begin
      unique case (op)
         OPC_MOVE: result = opnd_c;
         OPC_ADD:  result = sum;
         OPC_SUB:  result = diff;
         OPC_MUL:  result = prod;
         OPC_DIV:  result = quot;
         OPC_SHR:  result = shr_v;
         OPC_SHL:  result = shl_v;
         OPC_NAND: result = ~(opnd_b & opnd_c);
         OPC_XOR:  result = opnd_b ^ opnd_c;
         default:  result = '0;
      endcase
   end

   assign flags_we = (op == OPC_SUB);

   rm_alu_flags #(.WIDTH(WIDTH), .SIGN_POS(FLG_SIGN), .ZERO_POS(FLG_ZERO)) u_flags (
      .write_en(flags_we), .diff(diff), .flags_cur(flags_in), .flags_nxt(flags_out)
   );

   always_comb begin
      if (op == OPC_DIV && opnd_c == '0) begin
         p_div_zero_r4: assert (result == '1) else $error("divide by zero not all ones");
      end
      if (!flags_we) begin
         p_flags_hold_r7: assert (flags_out == flags_in) else $error("flags changed without write");
      end
      if (flags_we) begin
         p_sign_r8: assert (flags_out[FLG_SIGN] == result[WIDTH-1]) else $error("sign flag mismatch");
         p_zero_r9: assert (flags_out[FLG_ZERO] == (opnd_b == opnd_c)) else $error("zero flag mismatch");
         p_resv_r10: assert (flags_out[WIDTH-1:2] == '0) else $error("reserved flag bits set");
      end
   end
endmodule

// File: tb/sim_rm_alu.sv
module sim_rm_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op = 4'h0;
   logic [31:0] b = '0, c = '0, fin = '0;
   logic [31:0] result, fout;
   logic        we;
   int checks = 0, fails = 0;

   always #2.5 clk = ~clk;

   rm_alu u0 (.op(op), .opnd_b(b), .opnd_c(c), .flags_in(fin),
              .result(result), .flags_out(fout), .flags_we(we));

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic apply(input logic [3:0] o, input logic [31:0] vb, input logic [31:0] vc,
                        input logic [31:0] vf);
      @(negedge clk);
      op = o; b = vb; c = vc; fin = vf;
      #2;
   endtask

   task automatic t_reset;
      chk("R11 reset result", result, 32'h0);
      chk("R11 reset we", {31'h0, we}, 32'h0);
   endtask

   task automatic t_move;
      apply(4'h1, 32'h1111_2222, 32'hDEAD_BEEF, 32'h5);
      chk("R1 move", result, 32'hDEAD_BEEF);
   endtask

   task automatic t_addsub;
      apply(4'h2, 32'hFFFF_FFFF, 32'h2, 32'h0000_ABCD);
      chk("R2 add wrap", result, 32'h1);
      chk("R7 add no we", {31'h0, we}, 32'h0);
      chk("R7 add flags kept", fout, 32'h0000_ABCD);
      apply(4'h3, 32'h5, 32'h7, 32'h0);
      chk("R2 sub wrap", result, 32'hFFFF_FFFE);
      chk("R7 sub we", {31'h0, we}, 32'h1);
      chk("R8 sign set", fout, 32'h1);
   endtask

   task automatic t_flags;
      apply(4'h3, 32'h1234, 32'h1234, 32'hFFFF_FFFF);
      chk("R9 zero flag", fout, 32'h2);
      chk("R10 reserved cleared", fout & 32'hFFFF_FFFC, 32'h0);
      apply(4'h3, 32'h9, 32'h4, 32'hFFFF_FFFF);
      chk("R8 positive diff flags", fout, 32'h0);
   endtask

   task automatic t_muldiv;
      apply(4'h4, 32'h0001_0000, 32'h0001_0003, 32'h0);
      chk("R3 mul truncate", result, 32'h0003_0000);
      apply(4'h5, 32'd100, 32'd7, 32'h0);
      chk("R4 div", result, 32'd14);
      apply(4'h5, 32'hFFFF_FFFF, 32'h2, 32'h0);
      chk("R4 div unsigned", result, 32'h7FFF_FFFF);
      apply(4'h5, 32'h1234, 32'h0, 32'h0);
      chk("R4 div by zero", result, 32'hFFFF_FFFF);
   endtask

   task automatic t_shift;
      apply(4'h6, 32'h8000_0000, 32'd33, 32'h0);
      chk("R5 shr low bits", result, 32'h4000_0000);
      apply(4'h7, 32'h1, 32'd31, 32'h0);
      chk("R5 shl", result, 32'h8000_0000);
      apply(4'h7, 32'hA5A5_0001, 32'd32, 32'h0);
      chk("R5 shl amount wraps", result, 32'hA5A5_0001);
   endtask

   task automatic t_logic;
      apply(4'h8, 32'hF0F0_FF00, 32'hFF00_F0F0, 32'h3);
      chk("R6 nand", result, 32'h0FFF_0FFF);
      chk("R7 nand flags kept", fout, 32'h3);
      apply(4'h9, 32'hF0F0_FF00, 32'hFF00_F0F0, 32'h0);
      chk("R6 xor", result, 32'h0FF0_0FF0);
   endtask

   task automatic t_undef;
      apply(4'h0, 32'h1, 32'h2, 32'h7);
      chk("R11 op0 result", result, 32'h0);
      chk("R11 op0 flags", fout, 32'h7);
      apply(4'hF, 32'h1, 32'h2, 32'h7);
      chk("R11 opF result", result, 32'h0);
      chk("R11 opF we", {31'h0, we}, 32'h0);
   endtask

   initial begin
      #100000;
      fails++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk); #2;
      t_reset();
      t_move();
      t_addsub();
      t_flags();
      t_muldiv();
      t_shift();
      t_logic();
      t_undef();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule